// File: doc/BRIEF.md
# Byte-Loadable Address Counter

This block is a 16-bit address register with a self-increment, for a processor whose data path is only 8 bits wide. One design serves two roles: the instruction pointer and the operand address register. A full address arrives as two bytes over the narrow data bus, one byte per cycle. A byte-select input decides which half of the register each byte replaces, and the other half is kept. Between loads the register can step forward by one, so that consecutive bytes can be fetched without an arithmetic unit.

The current value is always visible on a dedicated output. A separate drive input presents the value on a shared address bus and raises a bus-enable flag. When the drive input is low, the bus copy is forced to zero and the flag is low, so several such registers can take turns on one address bus. The incrementer has two parameter-selected forms: a plain adder, or a chain of narrow counter segments linked by carries.

Top module: `addr_byte_counter`

## Requirements
- R1: The register holds 16 bits. While `rst_n` is low, and on the first cycle after it rises, `value_o` reads 0x0000.
- R2: With `inc_en` high and `load_en` low, each rising clock edge adds 1 to `value_o`.
- R3: With `load_en` high and `hi_sel` low, a clock edge copies `data_i` into bits 7:0 of `value_o`.
- R4: With `load_en` high and `hi_sel` high, a clock edge copies `data_i` into bits 15:8 of `value_o`.
- R5: A load leaves the byte that was not selected unchanged.
- R6: An increment carries from bit 7 into bit 8 (0x00FF becomes 0x0100), and 0xFFFF wraps to 0x0000.
- R7: With `load_en` and `inc_en` both low, `value_o` keeps its value across clock edges.
- R8: When `load_en` and `inc_en` are high in the same cycle, only the load takes place: no increment is applied to either byte.
- R9: While `drive_en` is high, `addr_oe` is high and `addr_o` equals `value_o`. While `drive_en` is low, `addr_oe` is low and `addr_o` is 0x0000. `drive_en` never changes `value_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Add one to the register on the next edge |
| load_en | input | 1 | Load one byte from the data bus on the next edge |
| hi_sel | input | 1 | Byte select for a load: 0 = bits 7:0, 1 = bits 15:8 |
| data_i | input | 8 | Data bus byte |
| drive_en | input | 1 | Present the register on the address bus |
| value_o | output | 16 | Current register value |
| addr_oe | output | 1 | Address bus driver enable |
| addr_o | output | 16 | Address bus copy; zero when not driving |

## Verification
Every register bit reaches `value_o` directly, so a wrong internal state shows up one edge after the stimulus that caused it. Carry faults are exposed within one increment at the byte boundary (0x00FF) and at the top of the range (0xFFFF). A load that spills into the wrong byte, or a load that also increments, changes the byte that should have been kept, and this is visible on the very next cycle. A fault in the bus gating shows up combinationally on `addr_o` and `addr_oe` as soon as `drive_en` toggles.

// File: rtl/addr_cnt_pkg.sv
package addr_cnt_pkg;

   // Incrementer variants selectable per instance
   typedef enum logic [0:0] {
      INC_ADDER     = 1'b0,   // single full-width +1 adder
      INC_SEGMENTED = 1'b1    // cascaded narrow counter segments
   } inc_style_e;

   // Number of bytes that make up one address word
   localparam int unsigned LANES_PER_WORD = 2;

endpackage

// File: rtl/addr_cnt_incr.sv
module addr_cnt_incr
   import addr_cnt_pkg::*;
#(
   parameter int unsigned W      = 16,
   parameter int unsigned SEG_W  = 4,
   parameter inc_style_e  STYLE  = INC_SEGMENTED
) (
   input  logic [W-1:0] a_i,
   output logic [W-1:0] y_o
);
   localparam int unsigned NUM_SEG = W / SEG_W;

   if (STYLE == INC_ADDER) begin : g_adder
      assign y_o = a_i + {{(W-1){1'b0}}, 1'b1};
   end else begin : g_segmented
      if ((W % SEG_W) != 0) begin : g_bad_seg
         $error("addr_cnt_incr: W must be a multiple of SEG_W");
      end
      logic [NUM_SEG:0] carry;
      assign carry[0] = 1'b1;
      for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
         logic [SEG_W-1:0] seg;
         assign seg = a_i[s*SEG_W +: SEG_W];
         assign y_o[s*SEG_W +: SEG_W] = seg + {{(SEG_W-1){1'b0}}, carry[s]};
         assign carry[s+1] = carry[s] & (&seg);
      end
   end

endmodule

// File: rtl/addr_cnt_lane.sv
module addr_cnt_lane #(
   parameter int unsigned      W       = 8,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_any_i,   // a load targets some lane this cycle
   input  logic         load_here_i,  // the load targets this lane
   input  logic         inc_en_i,
   input  logic [W-1:0] data_i,
   input  logic [W-1:0] inc_slice_i,  // this lane's part of value+1
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= RST_VAL;
      end else if (load_any_i) begin
         if (load_here_i) q_o <= data_i;
      end else if (inc_en_i) begin
         q_o <= inc_slice_i;
      end
   end

endmodule

// File: rtl/addr_byte_counter.sv
module addr_byte_counter
   import addr_cnt_pkg::*;
#(
   parameter int unsigned          DATA_W      = 8,
   parameter int unsigned          SEG_W       = 4,
   parameter inc_style_e           INC_STYLE   = INC_SEGMENTED,
   parameter logic [2*DATA_W-1:0]  RESET_VALUE = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  inc_en,
   input  logic                  load_en,
   input  logic                  hi_sel,
   input  logic [DATA_W-1:0]     data_i,
   input  logic                  drive_en,
   output logic [2*DATA_W-1:0]   value_o,
   output logic                  addr_oe,
   output logic [2*DATA_W-1:0]   addr_o
);
   localparam int unsigned LANES  = LANES_PER_WORD;
   localparam int unsigned ADDR_W = LANES * DATA_W;

   if (DATA_W < 1) begin : g_bad_width
      $error("addr_byte_counter: DATA_W must be at least 1");
   end
   if (SEG_W < 1 || SEG_W > ADDR_W) begin : g_bad_seg
      $error("addr_byte_counter: SEG_W out of range");
   end

   logic [ADDR_W-1:0] incremented;

   addr_cnt_incr #(
      .W     (ADDR_W),
      .SEG_W (SEG_W),
      .STYLE (INC_STYLE)
   ) u_incr (
      .a_i (value_o),
      .y_o (incremented)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic sel;
      assign sel = (g == 0) ? ~hi_sel : hi_sel;

      addr_cnt_lane #(
         .W       (DATA_W),
         .RST_VAL (RESET_VALUE[g*DATA_W +: DATA_W])
      ) u_lane (
         .clk         (clk),
         .rst_n       (rst_n),
         .load_any_i  (load_en),
         .load_here_i (load_en & sel),
         .inc_en_i    (inc_en),
         .data_i      (data_i),
         .inc_slice_i (incremented[g*DATA_W +: DATA_W]),
         .q_o         (value_o[g*DATA_W +: DATA_W])
      );
   end

   assign addr_oe = drive_en;
   assign addr_o  = drive_en ? value_o : '0;

endmodule

// File: rtl/addr_cnt_chk.sv
module addr_cnt_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                inc_en,
   input logic                load_en,
   input logic                hi_sel,
   input logic [DATA_W-1:0]   data_i,
   input logic                drive_en,
   input logic [2*DATA_W-1:0] value_o,
   input logic                addr_oe,
   input logic [2*DATA_W-1:0] addr_o
);
   localparam int unsigned ADDR_W = 2 * DATA_W;

   AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      load_en && !hi_sel |=> value_o[DATA_W-1:0] == $past(data_i)); // R3

   AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      load_en && hi_sel |=> value_o[ADDR_W-1:DATA_W] == $past(data_i)); // R4

   AST_KEEP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      load_en && !hi_sel |=> $stable(value_o[ADDR_W-1:DATA_W])); // R5

   AST_KEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      load_en && hi_sel |=> $stable(value_o[DATA_W-1:0])); // R8

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      inc_en && !load_en |=> value_o == ADDR_W'($past(value_o) + 1'b1)); // R2

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      inc_en && !load_en && (&value_o) |=> value_o == '0); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !inc_en && !load_en |=> $stable(value_o)); // R7

   AST_BUS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      drive_en |-> addr_oe && addr_o == value_o); // R9

   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en |-> !addr_oe && addr_o == '0); // R9

endmodule

bind addr_byte_counter addr_cnt_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .inc_en   (inc_en),
   .load_en  (load_en),
   .hi_sel   (hi_sel),
   .data_i   (data_i),
   .drive_en (drive_en),
   .value_o  (value_o),
   .addr_oe  (addr_oe),
   .addr_o   (addr_o)
);

// File: tb/addr_byte_counter_tb_top.sv
module addr_byte_counter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inc_en = 1'b0;
   logic        load_en = 1'b0;
   logic        hi_sel = 1'b0;
   logic [7:0]  data_i = '0;
   logic        drive_en = 1'b0;
   logic [15:0] value_o;
   logic        addr_oe;
   logic [15:0] addr_o;

   int errors = 0;
   int checks = 0;

   typedef struct {
      logic [15:0] val;
      logic        oe;
      logic [15:0] bus;
      string       req;
   } exp_t;

   exp_t        sb_q[$];
   logic [15:0] model = 16'h0000;

   always #5 clk = ~clk;

   addr_byte_counter dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_en   (inc_en),
      .load_en  (load_en),
      .hi_sel   (hi_sel),
      .data_i   (data_i),
      .drive_en (drive_en),
      .value_o  (value_o),
      .addr_oe  (addr_oe),
      .addr_o   (addr_o)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: one cycle of stimulus, expected result pushed to the scoreboard
   task automatic step(input logic ld, input logic hi, input logic inc,
                       input logic drv, input logic [7:0] d, input string req);
      exp_t e;
      @(negedge clk);
      load_en = ld; hi_sel = hi; inc_en = inc; drive_en = drv; data_i = d;
      if (ld) begin
         if (hi) model = {d, model[7:0]};
         else    model = {model[15:8], d};
      end else if (inc) begin
         model = model + 16'h0001;
      end
      e.val = model;
      e.oe  = drv;
      e.bus = drv ? model : 16'h0000;
      e.req = req;
      sb_q.push_back(e);
   endtask

   // monitor: compare after each edge, away from the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.req, value_o, e.val);
            check({e.req, " bus"}, addr_o, e.bus);
            check({e.req, " oe"}, {15'd0, addr_oe}, {15'd0, e.oe});
         end
      end
   end

   initial begin
      #1000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset", value_o, 16'h0000);
      check("R9 reset bus", addr_o, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 after release", value_o, 16'h0000);

      // two-byte load, little-endian order
      step(1, 0, 0, 0, 8'hCD, "R3 load low");
      step(1, 1, 0, 0, 8'hAB, "R4 load high");
      step(1, 0, 0, 0, 8'h12, "R5 low load keeps high");
      step(1, 1, 0, 0, 8'h34, "R5 high load keeps low");
      step(0, 0, 1, 0, 8'h00, "R2 increment");
      step(0, 0, 1, 0, 8'h00, "R2 increment again");
      step(0, 0, 0, 0, 8'hFF, "R7 idle hold");
      step(0, 1, 0, 0, 8'h55, "R7 idle with select");
      // carry across the byte boundary
      step(1, 0, 0, 0, 8'hFF, "R6 setup low");
      step(1, 1, 0, 0, 8'h00, "R6 setup high");
      step(0, 0, 1, 0, 8'h00, "R6 byte carry");
      // wrap at the top
      step(1, 0, 0, 0, 8'hFF, "R6 setup low");
      step(1, 1, 0, 0, 8'hFF, "R6 setup high");
      step(0, 0, 1, 0, 8'h00, "R6 wrap");
      // load and increment together
      step(1, 0, 1, 0, 8'h10, "R8 low load beats increment");
      step(1, 1, 1, 0, 8'h20, "R8 high load beats increment");
      step(1, 0, 1, 0, 8'hFF, "R8 low all-ones load");
      // bus drive
      step(0, 0, 0, 1, 8'h00, "R9 drive hold");
      step(0, 0, 1, 1, 8'h00, "R9 drive with increment");
      step(0, 0, 0, 0, 8'h00, "R9 release bus");
      step(1, 1, 0, 1, 8'h7E, "R9 drive during load");
      // long run of increments through several carries
      for (int i = 0; i < 300; i++) step(0, 0, 1, i[0], 8'h00, "R2 run");
      step(0, 0, 0, 0, 8'h00, "R7 final hold");

      @(negedge clk);
      while (sb_q.size() > 0) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule